// File: doc/BRIEF.md
# Signed Min/Max Extremes Tracker with Read-Clear

This block watches a stream of signed 24-bit conversion results. Each result carries a 3-bit channel tag. The block keeps two running extremes: the largest value seen and the smallest value seen. For each extreme it also stores the channel that produced it. Software or a host sequencer reads the extremes through a simple register read. A strobe picks one of two 32-bit words, and the word appears combinationally on the read bus.

Reading a word does two things. It returns the current contents, and at the clock edge it re-arms that tracker to the opposite end of the signed range. After a re-arm, the next valid sample always replaces the stored extreme. The two trackers re-arm independently of each other. A sample that arrives in the same cycle as a read is not lost: the read still shows the old contents, and the re-armed tracker then takes that sample into account.

Top module: `xt_extremes`

## Requirements
- R1: After reset, the maximum word (rd_sel=0) reads 0x80000000 and the minimum word (rd_sel=1) reads 0x7FFFFF00.
- R2: A valid sample replaces the stored maximum only when it is strictly greater under signed two's-complement comparison. The sample's channel is stored together with it.
- R3: A valid sample replaces the stored minimum only when it is strictly smaller under signed two's-complement comparison. The sample's channel is stored together with it.
- R4: A sample equal to a stored extreme changes neither the value nor the channel of that extreme, so the earlier channel is kept.
- R5: Both read words carry the value in bits 31:8, zeros in bits 7:3 and the channel in bits 2:0. rd_sel=0 selects the maximum word and rd_sel=1 selects the minimum word.
- R6: A read (rd_en=1 at a clock edge) returns the word as it stands in that cycle. After the edge, the selected tracker holds its starting extreme: 0x800000 for the maximum, 0x7FFFFF for the minimum, with channel 0 in both cases.
- R7: When a valid sample arrives in the same cycle as a read, the read returns the old contents. After the edge, the selected tracker holds the result of comparing that sample against the starting extreme.
- R8: A read of one word leaves the other tracker unchanged.
- R9: Cycles with smp_valid=0 leave both trackers unchanged, whatever is on smp_data and smp_chan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Qualifies smp_data and smp_chan |
| smp_data | input | 24 | Signed sample value |
| smp_chan | input | 3 | Channel that produced the sample |
| rd_en | input | 1 | Read strobe; re-arms the selected tracker at the edge |
| rd_sel | input | 1 | 0 selects the maximum word, 1 selects the minimum word |
| rd_data | output | 32 | Selected packed word, combinational |

## Verification
The checker watches the following on every cycle:
- the zero padding in bits 7:3;
- that the maximum never falls and the minimum never rises while a sample arrives without a read of that word;
- that idle cycles leave both words stable;
- the exact re-armed value after a read, together with the other word staying stable;
- that a sample taken during a read is captured whole.

Some properties can only be shown by the bench's scenarios, which compare every read against a reference model. These are:
- that a tie keeps the first channel;
- that signed ordering holds across the zero crossing (for example, -1 beats -5);
- that garbage data with the valid strobe low is ignored;
- that the read itself returns the pre-edge contents.

// File: rtl/xt_pkg.sv
package xt_pkg;
    localparam int XT_DATA_W = 24;
    localparam int XT_CHAN_W = 3;
    localparam int XT_PAD_W  = 8;   // low byte of the word: padding plus channel

    typedef enum logic {
        XT_SEL_MAX = 1'b0,
        XT_SEL_MIN = 1'b1
    } xt_sel_e;
endpackage

// File: rtl/xt_tracker.sv
module xt_tracker #(
    parameter int DATA_W = xt_pkg::XT_DATA_W,
    parameter int CHAN_W = xt_pkg::XT_CHAN_W,
    parameter bit IS_MAX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic              rearm,
    output logic [DATA_W-1:0] ext_val,
    output logic [CHAN_W-1:0] ext_chan
);
    // Starting extreme: most negative for the maximum, most positive for the minimum.
    localparam logic [DATA_W-1:0] START_VAL = IS_MAX ?
        {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [CHAN_W-1:0] chan;
    } trk_t;

    trk_t base;
    trk_t trk_d;
    trk_t trk_q;
    logic beats;

    // Re-arm happens before the compare, so a same-cycle sample is kept.
    always_comb begin
        if (rearm) begin
            base.val  = START_VAL;
            base.chan = '0;
        end else begin
            base = trk_q;
        end
    end

    generate
        if (IS_MAX) begin : g_gt
            assign beats = $signed(smp_data) > $signed(base.val);
        end else begin : g_lt
            assign beats = $signed(smp_data) < $signed(base.val);
        end
    endgenerate

    always_comb begin
        trk_d = base;
        if (smp_valid && beats) begin
            trk_d.val  = smp_data;
            trk_d.chan = smp_chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.val  <= START_VAL;
            trk_q.chan <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign ext_val  = trk_q.val;
    assign ext_chan = trk_q.chan;
endmodule

// File: rtl/xt_pack.sv
module xt_pack #(
    parameter int DATA_W = xt_pkg::XT_DATA_W,
    parameter int CHAN_W = xt_pkg::XT_CHAN_W,
    parameter int PAD_W  = xt_pkg::XT_PAD_W
) (
    input  logic [DATA_W-1:0]       val,
    input  logic [CHAN_W-1:0]       chan,
    output logic [DATA_W+PAD_W-1:0] word
);
    localparam int ZERO_W = PAD_W - CHAN_W;

    always_comb begin
        word = {val, {ZERO_W{1'b0}}, chan};
    end
endmodule

// File: rtl/xt_extremes.sv
module xt_extremes #(
    parameter int DATA_W = xt_pkg::XT_DATA_W,
    parameter int CHAN_W = xt_pkg::XT_CHAN_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                smp_valid,
    input  logic [DATA_W-1:0]                   smp_data,
    input  logic [CHAN_W-1:0]                   smp_chan,
    input  logic                                rd_en,
    input  logic                                rd_sel,
    output logic [DATA_W+xt_pkg::XT_PAD_W-1:0]  rd_data
);
    import xt_pkg::*;

    localparam int WORD_W = DATA_W + XT_PAD_W;
    localparam int NTRK   = 2;

    xt_sel_e sel;
    logic [NTRK-1:0] rearm;
    logic [DATA_W-1:0] trk_val [NTRK];
    logic [CHAN_W-1:0] trk_chan[NTRK];
    logic [WORD_W-1:0] trk_word[NTRK];
    logic [WORD_W-1:0] max_word;
    logic [WORD_W-1:0] min_word;

    assign sel = xt_sel_e'(rd_sel);

    always_comb begin
        rearm = '0;
        if (rd_en) rearm[sel] = 1'b1;
    end

    // Index 0 tracks the maximum, index 1 the minimum.
    for (genvar i = 0; i < NTRK; i++) begin : g_trk
        xt_tracker #(
            .DATA_W (DATA_W),
            .CHAN_W (CHAN_W),
            .IS_MAX (i == 0)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp_data  (smp_data),
            .smp_chan  (smp_chan),
            .rearm     (rearm[i]),
            .ext_val   (trk_val[i]),
            .ext_chan  (trk_chan[i])
        );

        xt_pack #(
            .DATA_W (DATA_W),
            .CHAN_W (CHAN_W),
            .PAD_W  (XT_PAD_W)
        ) u_pack (
            .val  (trk_val[i]),
            .chan (trk_chan[i]),
            .word (trk_word[i])
        );
    end

    assign max_word = trk_word[0];
    assign min_word = trk_word[1];

    always_comb begin
        rd_data = (sel == XT_SEL_MIN) ? min_word : max_word;
    end
endmodule

// File: rtl/xt_extremes_chk.sv
module xt_extremes_chk #(
    parameter int DATA_W = xt_pkg::XT_DATA_W,
    parameter int CHAN_W = xt_pkg::XT_CHAN_W
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               smp_valid,
    input logic [DATA_W-1:0]                  smp_data,
    input logic [CHAN_W-1:0]                  smp_chan,
    input logic                               rd_en,
    input logic                               rd_sel,
    input logic [DATA_W+xt_pkg::XT_PAD_W-1:0] max_word,
    input logic [DATA_W+xt_pkg::XT_PAD_W-1:0] min_word
);
    localparam int PAD_W  = xt_pkg::XT_PAD_W;
    localparam int WORD_W = DATA_W + PAD_W;
    localparam logic [WORD_W-1:0] MAX_START = {1'b1, {(DATA_W-1){1'b0}}, {PAD_W{1'b0}}};
    localparam logic [WORD_W-1:0] MIN_START = {1'b0, {(DATA_W-1){1'b1}}, {PAD_W{1'b0}}};
    localparam logic [DATA_W-1:0] NEG_END   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam int ZERO_W = PAD_W - CHAN_W;

    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (max_word[PAD_W-1:CHAN_W] == '0) && (min_word[PAD_W-1:CHAN_W] == '0));

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !rd_en) |=> ($stable(max_word) && $stable(min_word)));

    p_max_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !(rd_en && !rd_sel)) |=>
        ($signed(max_word[WORD_W-1:PAD_W]) >= $signed($past(max_word[WORD_W-1:PAD_W]))));

    p_min_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !(rd_en && rd_sel)) |=>
        ($signed(min_word[WORD_W-1:PAD_W]) <= $signed($past(min_word[WORD_W-1:PAD_W]))));

    p_rearm_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && !smp_valid) |=> (max_word == MAX_START));

    p_rearm_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel && !smp_valid) |=> (min_word == MIN_START));

    p_other_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && !smp_valid) |=> $stable(min_word));

    p_other_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel && !smp_valid) |=> $stable(max_word));

    p_read_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && smp_valid && smp_data != NEG_END) |=>
        (max_word == {$past(smp_data), {ZERO_W{1'b0}}, $past(smp_chan)}));
endmodule

bind xt_extremes xt_extremes_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_chan  (smp_chan),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .max_word  (max_word),
    .min_word  (min_word)
);

// File: tb/tb_xt_extremes.sv
module tb_xt_extremes;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic [2:0]  smp_chan = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] word;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference model state
    logic signed [23:0] m_max = 24'sh800000;
    logic [2:0]         m_maxc = '0;
    logic signed [23:0] m_min = 24'sh7FFFFF;
    logic [2:0]         m_minc = '0;

    always #5 clk = ~clk;

    xt_extremes dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_chan  (smp_chan),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; pushes the expected read word, then updates the model.
    task automatic step(input bit v, input logic [23:0] d, input logic [2:0] c,
                        input bit rd, input bit sel, input string tag);
        exp_t e;
        @(posedge clk);
        #2;
        smp_valid = v; smp_data = d; smp_chan = c; rd_en = rd; rd_sel = sel;
        if (rd) begin
            e.word = sel ? {m_min, 5'b0, m_minc} : {m_max, 5'b0, m_maxc};
            e.tag  = tag;
            exp_q.push_back(e);
            if (sel) begin m_min = 24'sh7FFFFF; m_minc = '0; end
            else     begin m_max = 24'sh800000; m_maxc = '0; end
        end
        if (v) begin
            if ($signed(d) > m_max) begin m_max = d; m_maxc = c; end
            if ($signed(d) < m_min) begin m_min = d; m_minc = c; end
        end
    endtask

    task automatic idle();
        step(1'b0, 24'h0, 3'd0, 1'b0, 1'b0, "");
    endtask

    // Monitor: compares each read against the scoreboard away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL scoreboard: unexpected read, actual %08h expected none", rd_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data, e.word, e.tag);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(rd_data, 32'h80000000, "R1 max reset");
        rd_sel = 1'b1;
        #1 check(rd_data, 32'h7FFFFF00, "R1 min reset");
        rd_sel = 1'b0;

        // R1 through reads
        step(0, 24'h0, 0, 1, 0, "R1 read max");
        step(0, 24'h0, 0, 1, 1, "R1 read min");

        // R2/R3/R5: mixed signed samples
        step(1, 24'd100,    3'd1, 0, 0, "");
        step(1, -24'sd5,    3'd2, 0, 0, "");
        step(1, 24'h7FFFFF, 3'd3, 0, 0, "");
        step(1, 24'h800001, 3'd6, 0, 0, "");
        step(1, 24'd42,     3'd7, 0, 0, "");
        step(0, 24'h0, 0, 1, 0, "R2 R5 max word");
        step(0, 24'h0, 0, 1, 1, "R3 R5 min word");

        // R4: ties keep the earlier channel
        step(1, 24'd50,   3'd4, 0, 0, "");
        step(1, 24'd50,   3'd6, 0, 0, "");
        step(1, -24'sd9,  3'd5, 0, 0, "");
        step(1, -24'sd9,  3'd2, 0, 0, "");
        step(0, 24'h0, 0, 1, 0, "R4 max tie");
        step(0, 24'h0, 0, 1, 1, "R4 min tie");

        // R6/R8: re-arm and independence
        step(1, 24'd300,  3'd3, 0, 0, "");
        step(1, -24'sd300,3'd1, 0, 0, "");
        step(0, 24'h0, 0, 1, 0, "R6 max before rearm");
        step(0, 24'h0, 0, 1, 1, "R8 min untouched by max read");
        step(0, 24'h0, 0, 1, 0, "R6 max rearmed");
        step(1, 24'd12,   3'd4, 0, 0, "");
        step(0, 24'h0, 0, 1, 0, "R8 max after min read");

        // R7: sample in the same cycle as a read
        step(1, 24'd77,  3'd2, 0, 0, "");
        step(1, 24'd7,   3'd5, 1, 0, "R7 read returns old max");
        step(0, 24'h0, 0, 1, 0, "R7 max holds same-cycle sample");
        step(1, 24'd9,   3'd1, 0, 0, "");
        step(1, 24'd20,  3'd6, 1, 1, "R7 read returns old min");
        step(0, 24'h0, 0, 1, 1, "R7 min holds same-cycle sample");

        // R9: invalid cycles carry garbage
        step(1, 24'd15, 3'd3, 0, 0, "");
        step(0, 24'h7FFFFF, 3'd7, 0, 0, "");
        step(0, 24'h800000, 3'd6, 0, 0, "");
        step(0, 24'h0, 0, 1, 0, "R9 max ignores invalid");
        step(0, 24'h0, 0, 1, 1, "R9 min ignores invalid");

        // R2 signed: all negative samples
        step(1, -24'sd5, 3'd1, 0, 0, "");
        step(1, -24'sd1, 3'd2, 0, 0, "");
        step(1, -24'sd8, 3'd3, 0, 0, "");
        step(0, 24'h0, 0, 1, 0, "R2 negative max");
        step(0, 24'h0, 0, 1, 1, "R3 negative min");
        idle();
        idle();

        if (exp_q.size() != 0) begin
            n_checks++; n_fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule